// File: doc/BRIEF.md
# Flash Page-Erase and Halfword-Program Sequencer

This block sits between a processor bus and a flash array. Software hands it a command: erase one page, or program a run of consecutive halfwords. The block then steps the array strobes for the required time. Erase and program durations are counted in clock cycles, derived from a clock-frequency parameter. A page erase takes 20 ms and one halfword program takes 50 µs. While any operation or abort runs, instruction fetches from flash are held off through a stall output.

An enabled, pending interrupt cuts an erase or program short. The array strobe drops on the next clock. The block then spends a fixed number of cycles quiescing before it frees the fetch path, so the core can take the interrupt. Nothing of the interrupted command is resumed. The status shows it as aborted, and software must issue the whole command again. The done, aborted and error flags each stay set until the next command that is accepted.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset the block is idle: busy, fetchStall, done, aborted, cmdError, arrErase, arrProg and dataTake are all 0.
- R2: A command with cmdOp = 2'b01 erases a page. arrAddr takes cmdAddr with its low 9 bits cleared (512-byte page). arrErase, busy and fetchStall are then high for exactly ERASE_CYC = CLK_HZ/50 cycles, after which done is 1.
- R3: A command with cmdOp = 2'b10 programs cmdLen+1 halfwords back to back. Each halfword keeps arrProg high for WRITE_CYC = CLK_HZ/20000 cycles. Halfword i uses arrAddr = cmdAddr + 2*i. Its data is the wrData value present in the cycle where dataTake pulses for it. dataTake pulses once per halfword: in the accept cycle, then in the last cycle of each halfword but the final one. After the last halfword, done is 1.
- R4: A program command whose cmdAddr bit 0 is 1, or any cmdOp of 2'b00 or 2'b11, starts nothing (busy stays 0) and sets cmdError.
- R5: A command presented while busy is ignored. The running operation keeps its address and total duration, and cmdError is set.
- R6: If irqPending is high in any cycle of an erase or program, arrErase/arrProg are low from the next cycle. busy and fetchStall then stay high for exactly ABORT_CYC further cycles, after which aborted is 1 and done is 0.
- R7: done, aborted and cmdError hold their value until the next accepted command, which clears all three. done and aborted are never both 1.
- R8: irqPending has no effect while the block is idle or already aborting: it neither starts an operation nor changes status, and the abort phase still lasts ABORT_CYC cycles.
- R9: fetchStall equals busy in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command strobe, one cycle |
| cmdOp | input | 2 | 01 erase page, 10 program halfwords, others rejected |
| cmdAddr | input | ADDR_W | Byte address of the page or first halfword |
| cmdLen | input | LEN_W | Halfword count minus one for program |
| wrData | input | 16 | Halfword data, taken when dataTake is high |
| irqPending | input | 1 | An enabled interrupt is pending |
| dataTake | output | 1 | wrData is captured at this clock edge |
| arrErase | output | 1 | Array erase strobe |
| arrProg | output | 1 | Array program strobe |
| arrAddr | output | ADDR_W | Array byte address |
| arrData | output | 16 | Halfword being programmed |
| fetchStall | output | 1 | Hold off instruction fetch from flash |
| busy | output | 1 | Operation or abort in progress |
| done | output | 1 | Last command completed normally |
| aborted | output | 1 | Last command was cut short by an interrupt |
| cmdError | output | 1 | A command was rejected |

## Verification
The bench goes after the edges of the timing windows.

- **Burst lengths.** Every burst length from one to sixteen halfwords is checked at several bases. A design with an off-by-one reload would miscount the total duration or the dataTake pulses.
- **Abort offsets.** Interrupts are fired at every cycle offset of a three-halfword burst, and at the first and last cycles of an erase. A design that gave completion priority over abort, or that mis-sized the quiescing window, would show done instead of aborted, or a stall of the wrong length.
- **Rejected and ignored commands.** Misaligned and reserved commands, and commands arriving mid-erase, are applied. A faulty block would either start a stray operation or disturb the one already running.
- **Sticky status.** Each new command is checked to clear the flags left by the previous one.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_ERASE = 2'b01,
    OP_WRITE = 2'b10,
    OP_RSVD  = 2'b11
  } fpcOpT;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ERASE,
    ST_PROG,
    ST_ABORT
  } fpcStateT;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadErase;
    logic loadWrite;
    logic nextHalf;
    logic startAbort;
  } fpcStrobeT;

endpackage

// File: rtl/fpc_datapath.sv
module fpc_datapath
  import fpc_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int LEN_W      = 4,
  parameter int PAGE_BYTES = 512,
  parameter int TIMER_W    = 19,
  parameter int ERASE_CYC  = 409600,
  parameter int WRITE_CYC  = 1024,
  parameter int ABORT_CYC  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  fpcStrobeT         strobe,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [15:0]       wrData,
  output logic              timerZero,
  output logic              lastHalf,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [15:0]       arrData
);

  localparam int PAGE_LSB = $clog2(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'(PAGE_BYTES - 1);
  localparam logic [TIMER_W-1:0] ERASE_LOAD = TIMER_W'(ERASE_CYC - 1);
  localparam logic [TIMER_W-1:0] WRITE_LOAD = TIMER_W'(WRITE_CYC - 1);
  localparam logic [TIMER_W-1:0] ABORT_LOAD = TIMER_W'(ABORT_CYC - 1);

  logic [TIMER_W-1:0] timer;
  logic [LEN_W-1:0]   remain;

  // cycle timer for erase, program and abort phases
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strobe.loadErase) begin
      timer <= ERASE_LOAD;
    end else if (strobe.loadWrite || strobe.nextHalf) begin
      timer <= WRITE_LOAD;
    end else if (strobe.startAbort) begin
      timer <= ABORT_LOAD;
    end else if (timer != '0) begin
      timer <= timer - 1'b1;
    end
  end

  // address, halfword count and data latches
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arrAddr <= '0;
      remain  <= '0;
      arrData <= '0;
    end else begin
      if (strobe.loadErase) begin
        arrAddr <= cmdAddr & ~PAGE_MASK;
      end else if (strobe.loadWrite) begin
        arrAddr <= cmdAddr;
      end else if (strobe.nextHalf) begin
        arrAddr <= arrAddr + ADDR_W'(2);
      end
      if (strobe.loadWrite) begin
        remain <= cmdLen;
      end else if (strobe.nextHalf) begin
        remain <= remain - 1'b1;
      end
      if (strobe.loadWrite || strobe.nextHalf) begin
        arrData <= wrData;
      end
    end
  end

  assign timerZero = (timer == '0);
  assign lastHalf  = (remain == '0);

  p_page_aligned_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadErase |=> (arrAddr[PAGE_LSB-1:0] == '0));

  p_half_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.nextHalf |=> (arrAddr == $past(arrAddr) + ADDR_W'(2)));

  p_count_down_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.nextHalf |=> (remain == $past(remain) - 1'b1));

  p_timer_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startAbort |=> (timer == ABORT_LOAD));

endmodule

// File: rtl/fpc_control.sv
module fpc_control
  import fpc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       cmdAddrLsb,
  input  logic       irqPending,
  input  logic       timerZero,
  input  logic       lastHalf,
  output fpcStrobeT  strobe,
  output logic       busy,
  output logic       done,
  output logic       aborted,
  output logic       cmdError,
  output logic       arrErase,
  output logic       arrProg
);

  fpcStateT state, nextState;
  logic finish, abortEnd, reject, accepted;

  always_comb begin
    strobe    = '0;
    nextState = state;
    finish    = 1'b0;
    abortEnd  = 1'b0;
    reject    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          if (fpcOpT'(cmdOp) == OP_ERASE) begin
            strobe.loadErase = 1'b1;
            nextState        = ST_ERASE;
          end else if (fpcOpT'(cmdOp) == OP_WRITE && !cmdAddrLsb) begin
            strobe.loadWrite = 1'b1;
            nextState        = ST_PROG;
          end else begin
            reject = 1'b1;
          end
        end
      end
      ST_ERASE: begin
        if (irqPending) begin
          strobe.startAbort = 1'b1;
          nextState         = ST_ABORT;
        end else if (timerZero) begin
          finish    = 1'b1;
          nextState = ST_IDLE;
        end
      end
      ST_PROG: begin
        if (irqPending) begin
          strobe.startAbort = 1'b1;
          nextState         = ST_ABORT;
        end else if (timerZero) begin
          if (lastHalf) begin
            finish    = 1'b1;
            nextState = ST_IDLE;
          end else begin
            strobe.nextHalf = 1'b1;
          end
        end
      end
      default: begin
        if (timerZero) begin
          abortEnd  = 1'b1;
          nextState = ST_IDLE;
        end
      end
    endcase
  end

  assign accepted = strobe.loadErase | strobe.loadWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      done     <= 1'b0;
      aborted  <= 1'b0;
      cmdError <= 1'b0;
    end else begin
      state <= nextState;
      if (accepted) begin
        done     <= 1'b0;
        aborted  <= 1'b0;
        cmdError <= 1'b0;
      end else begin
        if (reject || (cmdValid && state != ST_IDLE)) cmdError <= 1'b1;
        if (finish)   done    <= 1'b1;
        if (abortEnd) aborted <= 1'b1;
      end
    end
  end

  assign busy     = (state != ST_IDLE);
  assign arrErase = (state == ST_ERASE);
  assign arrProg  = (state == ST_PROG);

  p_busy_cmd_flagged_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdValid) |=> cmdError);

  p_bad_cmd_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdValid && cmdOp == OP_WRITE && cmdAddrLsb) |=> (!busy && cmdError));

  p_abort_drops_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((arrErase || arrProg) && irqPending) |=> (busy && !arrErase && !arrProg));

  p_status_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(done && aborted));

  p_idle_stays_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !cmdValid) |=> !busy);

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import fpc_pkg::*;
#(
  parameter int CLK_HZ     = 20_480_000,
  parameter int ADDR_W     = 17,
  parameter int LEN_W      = 4,
  parameter int PAGE_BYTES = 512,
  parameter int ABORT_CYC  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [15:0]       wrData,
  input  logic              irqPending,
  output logic              dataTake,
  output logic              arrErase,
  output logic              arrProg,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [15:0]       arrData,
  output logic              fetchStall,
  output logic              busy,
  output logic              done,
  output logic              aborted,
  output logic              cmdError
);

  // 20 ms erase, 50 us halfword program
  localparam int ERASE_CYC = CLK_HZ / 50;
  localparam int WRITE_CYC = CLK_HZ / 20000;
  localparam int MAX_CYC   = (ERASE_CYC > ABORT_CYC) ? ERASE_CYC : ABORT_CYC;
  localparam int TIMER_W   = $clog2(MAX_CYC + 1);

  fpcStrobeT strobe;
  logic timerZero, lastHalf;

  fpc_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdOp      (cmdOp),
    .cmdAddrLsb (cmdAddr[0]),
    .irqPending (irqPending),
    .timerZero  (timerZero),
    .lastHalf   (lastHalf),
    .strobe     (strobe),
    .busy       (busy),
    .done       (done),
    .aborted    (aborted),
    .cmdError   (cmdError),
    .arrErase   (arrErase),
    .arrProg    (arrProg)
  );

  fpc_datapath #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .PAGE_BYTES (PAGE_BYTES),
    .TIMER_W    (TIMER_W),
    .ERASE_CYC  (ERASE_CYC),
    .WRITE_CYC  (WRITE_CYC),
    .ABORT_CYC  (ABORT_CYC)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmdAddr   (cmdAddr),
    .cmdLen    (cmdLen),
    .wrData    (wrData),
    .timerZero (timerZero),
    .lastHalf  (lastHalf),
    .arrAddr   (arrAddr),
    .arrData   (arrData)
  );

  assign dataTake   = strobe.loadWrite | strobe.nextHalf;
  assign fetchStall = busy;

endmodule

// File: tb/flash_prog_ctrl_test.sv
module flash_prog_ctrl_test;

  localparam int CLK_HZ = 200_000;
  localparam int AW     = 12;
  localparam int LW     = 4;
  localparam int ABT    = 10;
  localparam int ECYC   = CLK_HZ / 50;
  localparam int WCYC   = CLK_HZ / 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'b00;
  logic [AW-1:0] cmdAddr = '0;
  logic [LW-1:0] cmdLen = '0;
  logic [15:0] wrData = '0;
  logic irqPending = 1'b0;
  logic dataTake, arrErase, arrProg, fetchStall, busy, done, aborted, cmdError;
  logic [AW-1:0] arrAddr;
  logic [15:0] arrData;

  int vectors = 0;
  int errs = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  flash_prog_ctrl #(.CLK_HZ(CLK_HZ), .ADDR_W(AW), .LEN_W(LW), .PAGE_BYTES(512), .ABORT_CYC(ABT)) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdLen(cmdLen), .wrData(wrData), .irqPending(irqPending), .dataTake(dataTake),
    .arrErase(arrErase), .arrProg(arrProg), .arrAddr(arrAddr), .arrData(arrData),
    .fetchStall(fetchStall), .busy(busy), .done(done), .aborted(aborted), .cmdError(cmdError)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int addr, input int idx);
    return 16'(addr * 7 + idx * 16'h1111 + 16'h5A);
  endfunction

  // program a burst and check every cycle of it (R3, R7, R9)
  task automatic doWrite(input int addr, input int len);
    int t = 0;
    int takes = 0;
    int bad = 0;
    int stallBad = 0;
    wrData = pat(addr, 0); cmdValid = 1'b1; cmdOp = 2'b10;
    cmdAddr = AW'(addr); cmdLen = LW'(len);
    #1;
    if (dataTake) takes++;
    @(negedge clk);
    cmdValid = 1'b0;
    chk(!done && !aborted && !cmdError && busy, "R7 flags cleared on accept", {done, aborted, cmdError}, 0);
    while (busy && t < 100000) begin
      int idx = t / WCYC;
      wrData = pat(addr, idx + 1);
      #1;
      if (dataTake) takes++;
      if (!arrProg || arrErase || arrAddr != AW'(addr + 2 * idx) || arrData != pat(addr, idx)) bad++;
      if (fetchStall != busy) stallBad++;
      t++;
      @(negedge clk);
    end
    chk(t == (len + 1) * WCYC, "R3 burst duration", t, (len + 1) * WCYC);
    chk(takes == len + 1, "R3 dataTake count", takes, len + 1);
    chk(bad == 0, "R3 address/data per halfword", bad, 0);
    chk(stallBad == 0 && !fetchStall, "R9 stall follows busy", stallBad, 0);
    chk(done && !aborted && !cmdError, "R7 done after program", {done, aborted, cmdError}, 3'b100);
  endtask

  // page erase, optionally with a command thrown in mid-operation (R2, R5)
  task automatic doErase(input int addr, input int hitAt);
    int t = 0;
    int bad = 0;
    int expAddr = addr & ~511;
    cmdValid = 1'b1; cmdOp = 2'b01; cmdAddr = AW'(addr);
    @(negedge clk);
    cmdValid = 1'b0;
    while (busy && t < 100000) begin
      if (t == hitAt) begin
        cmdValid = 1'b1; cmdOp = 2'b10; cmdAddr = AW'(12'h10); cmdLen = '0;
      end else begin
        cmdValid = 1'b0;
      end
      #1;
      if (!arrErase || arrProg || arrAddr != AW'(expAddr) || fetchStall != busy) bad++;
      t++;
      @(negedge clk);
    end
    cmdValid = 1'b0;
    chk(t == ECYC, "R2 erase duration", t, ECYC);
    chk(bad == 0, "R2 erase strobe and page address", bad, 0);
    chk(done && !aborted, "R2 done after erase", {done, aborted}, 2'b10);
    if (hitAt >= 0)
      chk(cmdError == 1'b1, "R5 command while busy flagged", cmdError, 1);
  endtask

  // start an op, raise irqPending at busy cycle k (R6, R8)
  task automatic doAbort(input bit isErase, input int k, input bit holdIrq);
    int t = 0;
    int a = 0;
    cmdValid = 1'b1; cmdOp = isErase ? 2'b01 : 2'b10; cmdAddr = AW'(12'h100);
    cmdLen = LW'(2); wrData = 16'h1234;
    @(negedge clk);
    cmdValid = 1'b0;
    while (t < k) begin
      t++;
      @(negedge clk);
    end
    irqPending = 1'b1;
    @(negedge clk);
    irqPending = holdIrq;
    chk(busy && fetchStall && !arrErase && !arrProg, "R6 strobe drops after irq",
        {busy, fetchStall, arrErase, arrProg}, 4'b1100);
    while (busy && a < 1000) begin
      a++;
      @(negedge clk);
    end
    chk(a == ABT, holdIrq ? "R8 abort length with irq held" : "R6 abort length", a, ABT);
    chk(aborted && !done, "R6 aborted status", {aborted, done}, 2'b10);
    repeat (3) @(negedge clk);
    chk(!busy && aborted, "R8 irq while idle ignored", {busy, aborted}, 2'b01);
    irqPending = 1'b0;
  endtask

  initial begin
    while (cycles < 190000) begin
      @(posedge clk);
      cycles++;
    end
    errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, fetchStall, done, aborted, cmdError, arrErase, arrProg, dataTake} == 8'b0,
        "R1 reset state", {busy, fetchStall, done, aborted, cmdError, arrErase, arrProg, dataTake}, 0);
    rstN = 1'b1;
    @(negedge clk);

    doErase(12'h000, -1);
    doErase(12'h3FF, -1);
    doErase(12'hA55, -1);
    doErase(12'h7FE, 100);

    for (int b = 0; b < 3; b++) begin
      for (int n = 0; n < 16; n++) begin
        doWrite(b == 0 ? 12'h000 : (b == 1 ? 12'h2A4 : 12'hC02), n);
      end
    end

    // rejected commands (R4)
    for (int v = 0; v < 3; v++) begin
      doWrite(12'h040, 0);
      cmdValid = 1'b1;
      cmdOp = (v == 0) ? 2'b10 : (v == 1 ? 2'b00 : 2'b11);
      cmdAddr = (v == 0) ? AW'(12'h041) : AW'(12'h040);
      @(negedge clk);
      cmdValid = 1'b0;
      chk(!busy && !arrProg && !arrErase && cmdError, "R4 rejected command",
          {busy, arrProg, arrErase, cmdError}, 4'b0001);
      @(negedge clk);
      chk(!busy && cmdError && done, "R7 error and done sticky", {busy, cmdError, done}, 3'b011);
    end

    for (int k = 0; k < 3 * WCYC; k++) begin
      doAbort(1'b0, k, k == 5);
      doWrite(12'h080, 1);
    end
    doAbort(1'b1, 0, 1'b0);
    doAbort(1'b1, 1, 1'b1);
    doAbort(1'b1, ECYC / 2, 1'b0);
    doAbort(1'b1, ECYC - 1, 1'b0);
    doErase(12'h200, -1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

endmodule